// File: doc/BRIEF.md
# Cascadable Dual Countdown Timer

This block holds two 16-bit down-counters, timer A and timer B. Each one has a reload latch that is only written and a small control register. A host reaches all of them through an 8-bit register bus with a write strobe. Reads on that bus are combinational. A timer is started by setting its START bit. It then counts down on each enabled count event, and it underflows on the tick where the counter already holds zero. On that tick the counter reloads from its latch. In continuous mode the timer keeps running after the reload. In one-shot mode it stops after the reload.

Timer A counts either every clock cycle or the rising edges of an external count input. Timer B has four sources: the clock, count-input rising edges, timer A underflows, or timer A underflows that occur while the count input is high. The third source chains the two timers into one 32-bit timer. The fourth measures how long an external pulse stays high. Each timer raises a one-cycle underflow flag for an interrupt block. Each timer can also drive one output pin, either as a one-cycle pulse per underflow or as a level that toggles on each underflow.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, both counters and both latches read 0xFFFF, both control registers read 0x00, and uf_flag, pb_out and pb_oe are all low.
- R2: Register addresses are 0 A low, 1 A high, 2 B low, 3 B high, 4 A control, 5 B control. A write to a timer byte changes only its latch. A read of a timer byte returns the live counter. A stopped counter holds its value.
- R3: An underflow is the tick on which START is 1, a count event occurs and the counter is zero. Its uf_flag bit (bit 0 A, bit 1 B) is high during the following clock cycle. With the clock source and latch L, underflows repeat every L+1 cycles.
- R4: In continuous mode (control bit 3 = 0), an underflow reloads the counter from the latch and counting goes on.
- R5: In one-shot mode (control bit 3 = 1), an underflow reloads the counter and clears START (bit 0), so the counter then holds.
- R6: Writing a control byte with bit 4 = 1 copies the latch into the counter at that edge. Bit 4 is not stored and reads as 0.
- R7: Writing a high byte while the timer is stopped copies the updated latch into the counter. The same write while the timer runs does not touch the counter.
- R8: Timer A control bit 5 = 1 makes timer A count rising edges of cnt_in, after cnt_in passes a two-flop synchroniser. Falling edges and steady levels do not count.
- R9: Timer B control bits 6:5 select its source: 00 clock, 01 cnt_in rising edges, 10 timer A underflows. With 10, a B underflow falls on the same tick as an A underflow.
- R10: With timer B source 11, timer B counts timer A underflows only while the synchronised cnt_in is high.
- R11: pb_oe bit 0/1 follows control bit 1 of A/B. While that bit is 0 the matching pb_out bit is low. In pulse mode (control bit 2 = 0), pb_out is high for exactly the cycles in which the matching uf_flag bit is high.
- R12: In toggle mode (control bit 2 = 1), a control write with START = 1 sets the output level high, and each underflow inverts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count tick per cycle for the clock source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| cnt_in | input | 1 | Asynchronous external count input |
| uf_flag | output | 2 | One-cycle underflow flags, bit 0 timer A, bit 1 timer B |
| pb_out | output | 2 | Timer output levels, bit 0 timer A, bit 1 timer B |
| pb_oe | output | 2 | Output enables for pb_out |

## Verification
A register write takes effect at the clock edge on which wr_en is high. The bench therefore reads the result half a cycle after that edge, before the next count edge can change it. uf_flag and the pulse-mode output are registered, so they appear one cycle after the underflow tick. The bench counts falling edges from the start write up to the flag and expects L+1 for latch L. A cnt_in change takes two to three cycles to reach the counters, so the cnt_in tests hold each level for five cycles and only check the count once the input has settled. They never check the exact cycle on which the count changes.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cnt_in,
  output logic [1:0]    uf_flag,
  output logic [1:0]    pb_out,
  output logic [1:0]    pb_oe
);
  localparam int CW = 2 * DW;
  localparam logic [DW-1:0] MASK_A = DW'(8'h2F);
  localparam logic [DW-1:0] MASK_B = DW'(8'h6F);

  logic [2:0]    cnt_sync;
  logic          cnt_rise, cnt_high;
  logic [CW-1:0] cnt_a, cnt_b, lat_a, lat_b, lat_a_nx, lat_b_nx;
  logic [DW-1:0] cr_a, cr_b;
  logic          evt_a, evt_b, tick_a, tick_b;
  logic          pls_a, pls_b, tog_a, tog_b;
  logic          w_alo, w_ahi, w_acr, w_blo, w_bhi, w_bcr;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_sync <= '0;
    else        cnt_sync <= {cnt_sync[1:0], cnt_in};
  end
  assign cnt_rise = cnt_sync[1] & ~cnt_sync[2];
  assign cnt_high = cnt_sync[1];

  assign w_alo = wr_en && addr == AW'(0);
  assign w_ahi = wr_en && addr == AW'(1);
  assign w_blo = wr_en && addr == AW'(2);
  assign w_bhi = wr_en && addr == AW'(3);
  assign w_acr = wr_en && addr == AW'(4);
  assign w_bcr = wr_en && addr == AW'(5);

  assign evt_a = cr_a[5] ? cnt_rise : 1'b1;
  always_comb begin
    case (cr_b[6:5])
      2'b00:   evt_b = 1'b1;
      2'b01:   evt_b = cnt_rise;
      2'b10:   evt_b = tick_a;
      default: evt_b = tick_a & cnt_high;
    endcase
  end
  assign tick_a = cr_a[0] & evt_a & (cnt_a == '0);
  assign tick_b = cr_b[0] & evt_b & (cnt_b == '0);

  always_comb begin
    lat_a_nx = lat_a;
    if (w_alo) lat_a_nx[DW-1:0]  = wr_data;
    if (w_ahi) lat_a_nx[CW-1:DW] = wr_data;
    lat_b_nx = lat_b;
    if (w_blo) lat_b_nx[DW-1:0]  = wr_data;
    if (w_bhi) lat_b_nx[CW-1:DW] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_a <= '1; cnt_a <= '1; cr_a <= '0;
      pls_a <= 1'b0; tog_a <= 1'b0; uf_flag[0] <= 1'b0;
    end else begin
      lat_a      <= lat_a_nx;
      uf_flag[0] <= tick_a;
      pls_a      <= tick_a;
      if (tick_a) tog_a <= ~tog_a;
      if (tick_a && cr_a[3]) cr_a[0] <= 1'b0;
      if (w_acr) begin
        cr_a <= wr_data & MASK_A;
        if (wr_data[0]) tog_a <= 1'b1;
      end
      if (w_acr && wr_data[4])     cnt_a <= lat_a;
      else if (w_ahi && !cr_a[0])  cnt_a <= lat_a_nx;
      else if (tick_a)             cnt_a <= lat_a;
      else if (cr_a[0] && evt_a)   cnt_a <= cnt_a - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_b <= '1; cnt_b <= '1; cr_b <= '0;
      pls_b <= 1'b0; tog_b <= 1'b0; uf_flag[1] <= 1'b0;
    end else begin
      lat_b      <= lat_b_nx;
      uf_flag[1] <= tick_b;
      pls_b      <= tick_b;
      if (tick_b) tog_b <= ~tog_b;
      if (tick_b && cr_b[3]) cr_b[0] <= 1'b0;
      if (w_bcr) begin
        cr_b <= wr_data & MASK_B;
        if (wr_data[0]) tog_b <= 1'b1;
      end
      if (w_bcr && wr_data[4])     cnt_b <= lat_b;
      else if (w_bhi && !cr_b[0])  cnt_b <= lat_b_nx;
      else if (tick_b)             cnt_b <= lat_b;
      else if (cr_b[0] && evt_b)   cnt_b <= cnt_b - 1'b1;
    end
  end

  assign pb_oe  = {cr_b[1], cr_a[1]};
  assign pb_out = {cr_b[1] & (cr_b[2] ? tog_b : pls_b),
                   cr_a[1] & (cr_a[2] ? tog_a : pls_a)};

  always_comb begin
    case (addr)
      AW'(0):  rd_data = cnt_a[DW-1:0];
      AW'(1):  rd_data = cnt_a[CW-1:DW];
      AW'(2):  rd_data = cnt_b[DW-1:0];
      AW'(3):  rd_data = cnt_b[CW-1:DW];
      AW'(4):  rd_data = cr_a;
      AW'(5):  rd_data = cr_b;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] lat_a,
  input logic [DW-1:0] cr_a,
  input logic [DW-1:0] cr_b,
  input logic          tick_a,
  input logic [1:0]    uf_flag,
  input logic [1:0]    pb_out,
  input logic [1:0]    pb_oe
);
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cr_a[0] && !wr_en) |=> $stable(cnt_a));

  a_r3_flag_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    uf_flag[0] |-> $past(cnt_a) == '0);

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && !wr_en) |=> cnt_a == $past(lat_a));

  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && cr_a[3] && !wr_en) |=> !cr_a[0]);

  a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_b[6:5] == 2'b10 && !tick_a && !wr_en) |=> $stable(cnt_b));

  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_oe[1] |-> !pb_out[1]);

  a_r12_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && cr_a[2] && cr_a[1] && !wr_en) |=> pb_out[0] != $past(pb_out[0]));
endmodule

bind dual_down_timer dual_down_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .lat_a(lat_a),
  .cr_a(cr_a), .cr_b(cr_b), .tick_a(tick_a),
  .uf_flag(uf_flag), .pb_out(pb_out), .pb_oe(pb_oe)
);

// File: tb/dual_down_timer_tb.sv
module dual_down_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       cnt_in = 1'b0;
  logic [1:0] uf_flag, pb_out, pb_oe;
  int total = 0;
  int bad = 0;

  dual_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_in(cnt_in), .uf_flag(uf_flag), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_flag(input int bit_i, output int n);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n++;
      if (uf_flag[bit_i]) break;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), d);
      chk("R1 counter byte", d, 8'hFF);
    end
    rd(3'd4, d); chk("R1 ctrl A", d, 0);
    rd(3'd5, d); chk("R1 ctrl B", d, 0);
    chk("R1 outputs", {uf_flag, pb_out, pb_oe}, 0);
  endtask

  task automatic t_continuous;
    logic [7:0] d;
    int n;
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h05);
    wr(3'd1, 8'h00);
    rd(3'd0, d); chk("R7 stopped hi write loads", d, 8'h05);
    wr(3'd4, 8'h01);
    wait_flag(0, n); chk("R3 first period", n, 6);
    rd(3'd0, d); chk("R4 reload value", d, 8'h05);
    wait_flag(0, n); chk("R4 second period", n, 6);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    int n;
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h09);
    wait_flag(0, n); chk("R5 one-shot period", n, 4);
    rd(3'd4, d); chk("R5 START cleared", d, 8'h08);
    rd(3'd0, d); chk("R5 reloaded", d, 8'h03);
    idle(5);
    rd(3'd0, d); chk("R2 stopped holds", d, 8'h03);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_force_load;
    logic [7:0] d;
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h01);
    idle(10);
    wr(3'd0, 8'h20);
    rd(3'd0, d);
    chk("R2 latch write leaves counter", int'(d != 8'h20 && d < 8'h40), 1);
    wr(3'd4, 8'h11);
    rd(3'd0, d); chk("R6 force load", d, 8'h20);
    rd(3'd4, d); chk("R6 LOAD not stored", d, 8'h01);
    wr(3'd1, 8'h12);
    rd(3'd1, d); chk("R7 running hi write no load", d, 8'h00);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_cnt_source;
    logic [7:0] d;
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h21);
    idle(10);
    rd(3'd0, d); chk("R8 no edges no count", d, 8'h03);
    for (int k = 0; k < 2; k++) begin
      cnt_in = 1'b1; idle(5);
      cnt_in = 1'b0; idle(5);
    end
    rd(3'd0, d); chk("R8 two rising edges", d, 8'h01);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_chain;
    int na;
    logic seen;
    wr(3'd0, 8'h02); wr(3'd1, 8'h00);
    wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    wr(3'd5, 8'h41);
    wr(3'd4, 8'h01);
    na = 0; seen = 1'b0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      if (uf_flag[0]) na++;
      if (uf_flag[1]) begin
        seen = 1'b1;
        chk("R9 B with A underflow", uf_flag[0], 1);
      end
    end
    chk("R9 B underflow seen", seen, 1);
    chk("R9 A underflows per B", na, 2);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_gated;
    logic [7:0] d;
    logic seen;
    cnt_in = 1'b0;
    wr(3'd2, 8'h03); wr(3'd3, 8'h00);
    wr(3'd5, 8'h61);
    wr(3'd4, 8'h11);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (uf_flag[1]) seen = 1'b1;
    end
    rd(3'd2, d); chk("R10 gated low holds", d, 8'h03);
    chk("R10 no B underflow while low", seen, 0);
    cnt_in = 1'b1;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (uf_flag[1]) seen = 1'b1;
    end
    chk("R10 counts while high", seen, 1);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    cnt_in = 1'b0;
  endtask

  task automatic t_pulse;
    int highs, mism;
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    wr(3'd4, 8'h03);
    chk("R11 enable A", pb_oe, 2'b01);
    highs = 0; mism = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pb_out[0]) highs++;
      if (pb_out[0] != uf_flag[0]) mism++;
      if (pb_out[1]) mism++;
    end
    chk("R11 pulse matches flag", mism, 0);
    chk("R11 pulses seen", int'(highs >= 4), 1);
    wr(3'd4, 8'h00);
    chk("R11 disabled low", pb_out, 0);
  endtask

  task automatic t_toggle;
    int n;
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    wr(3'd4, 8'h07);
    chk("R12 start sets high", pb_out[0], 1);
    wait_flag(0, n);
    chk("R12 first toggle", pb_out[0], 0);
    wait_flag(0, n);
    chk("R12 second toggle", pb_out[0], 1);
    chk("R12 period", n, 4);
    wr(3'd4, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_continuous;
    t_oneshot;
    t_force_load;
    t_cnt_source;
    t_chain;
    t_gated;
    t_pulse;
    t_toggle;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule